// File: doc/BRIEF.md
# Interrupt Status Register with Summaries

This block holds the interrupt and status word of a network controller. Single-cycle event pulses from the transmit and receive machinery, the general-purpose timer and the bus master set sticky bits. Software clears them by writing ones to the positions it has serviced. Two summary bits, one for routine events and one for error conditions, are derived from fixed groups of stored bits. A level interrupt line is raised whenever either summary is set.

A read returns the stored bits and the two summaries. It also returns two 2-bit process-state fields, built on the fly from the start bits of the operating-mode word. That word arrives on an input port and is not stored here.

The summaries come from a small state machine. Its register always matches the sticky bits captured at the same clock edge. The states are `SUM_IDLE` (no group bit set), `SUM_NORMAL` (only routine bits), `SUM_ABNORMAL` (only error bits) and `SUM_BOTH`. On every clock the machine moves to the state named by the next values of the two groups. Any transition between the four states is therefore legal, and a state may also follow itself. `SUM_IDLE` is the reset state.

Top module: `isr_status_block`

## Requirements
- R1: After reset the read word is 0xFC000000 and `irq_out` is low.
- R2: A pulse on `evt_in[i]` for i in {0,1,2,3,5,6,7,8,9,11,13} sets read bit i from the next clock edge. The bit then stays set until software clears it.
- R3: A write with `wr_en` high clears every stored bit whose `wr_data` bit is 1 and leaves bits written with 0 untouched.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit is set after that edge.
- R5: Read bit 16 is 1 exactly when any of bits 0, 2 or 6 is set.
- R6: Read bit 15 is 1 exactly when any of bits 1, 3, 5, 7, 8, 9, 11 or 13 is set.
- R7: `irq_out` is high exactly when read bit 15 or bit 16 is 1, in the same cycle the bits become visible.
- R8: Read bits 18:17 are 3 while `mode_in[1]` is 1 and 0 otherwise. Read bits 21:20 are 3 while `mode_in[13]` is 1 and 0 otherwise. Both fields follow `mode_in` without a clock delay, and no other `mode_in` bit changes the read word.
- R9: Writing ones to bits 15, 16, 17, 18, 20 or 21 has no effect, and pulses on `evt_in[4]`, `evt_in[10]` or `evt_in[12]` change nothing.
- R10: Bits 31:26 reset to 1 and are cleared by writing ones. No event sets them again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 14 | Event pulses; bit i sets status bit i |
| wr_en | input | 1 | Write strobe, clear-by-ones |
| wr_data | input | 32 | Write data, ones select bits to clear |
| mode_in | input | 32 | Operating-mode word; bits 1 and 13 are the start bits |
| rd_data | output | 32 | Composed status word |
| irq_out | output | 1 | Level interrupt request |

## Verification
An event pulse and a software clear can land on the same bit at the same clock edge. The race is provoked both directly, with a write of the same bit alongside a pulse, and through a long stretch of random pulses mixed with random clear masks. The outcome is judged against a behavioural model in the bench. That model applies the clear first and the event second, and it is compared with the read word and the interrupt line after every edge. A set bit must survive the collision, and its summary and the interrupt must stay up.

// File: rtl/isr_pkg.sv
package isr_pkg;

    localparam int          ISR_REG_W      = 32;
    localparam int          ISR_EVT_W      = 14;
    localparam logic [31:0] ISR_RESET_WORD = 32'hFC00_0000;
    localparam logic [31:0] ISR_NORM_GROUP = 32'h0000_0045;
    localparam logic [31:0] ISR_ABN_GROUP  = 32'h0000_2BAA;
    localparam logic [31:0] ISR_EVT_BITS   = ISR_NORM_GROUP | ISR_ABN_GROUP;

    localparam int ISR_ABN_SUM_POS  = 15;
    localparam int ISR_NORM_SUM_POS = 16;
    localparam int ISR_RX_FIELD_LSB = 17;
    localparam int ISR_TX_FIELD_LSB = 20;
    localparam int ISR_FIELD_W      = 2;
    localparam int ISR_MODE_RX_POS  = 1;
    localparam int ISR_MODE_TX_POS  = 13;

    typedef enum logic [1:0] {
        SUM_IDLE     = 2'b00,
        SUM_NORMAL   = 2'b01,
        SUM_ABNORMAL = 2'b10,
        SUM_BOTH     = 2'b11
    } sum_state_e;

endpackage

// File: rtl/isr_status_bits.sv
module isr_status_bits #(
    parameter int          REG_W    = isr_pkg::ISR_REG_W,
    parameter int          EVT_W    = isr_pkg::ISR_EVT_W,
    parameter logic [31:0] EVT_BITS = isr_pkg::ISR_EVT_BITS,
    parameter logic [31:0] RST_WORD = isr_pkg::ISR_RESET_WORD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_in,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_data,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] stat_d
);

    logic [REG_W-1:0] clr_mask;
    logic [REG_W-1:0] evt_wide;
    logic             unused_evt;

    assign clr_mask   = clr_en ? clr_data : '0;
    assign evt_wide   = REG_W'(evt_in) & EVT_BITS[REG_W-1:0];
    assign unused_evt = ^(evt_in & ~EVT_BITS[EVT_W-1:0]);

    // One storage cell per bit; the kind of cell is picked by the masks.
    for (genvar g = 0; g < REG_W; g++) begin : g_bit
        if (g < EVT_W && EVT_BITS[g]) begin : g_event_cell
            // set has priority over clear
            assign stat_d[g] = evt_wide[g] | (stat_q[g] & ~clr_mask[g]);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stat_q[g] <= RST_WORD[g];
                else        stat_q[g] <= stat_d[g];
            end
        end else if (RST_WORD[g]) begin : g_clear_only_cell
            assign stat_d[g] = stat_q[g] & ~clr_mask[g];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stat_q[g] <= 1'b1;
                else        stat_q[g] <= stat_d[g];
            end
        end else begin : g_zero_cell
            assign stat_d[g] = 1'b0;
            assign stat_q[g] = 1'b0;
        end
    end

    // R2: a stored bit never drops without a write
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R3: bits selected by a write and not hit by an event are cleared
    a_r3_clear_by_ones: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((stat_q & $past(clr_data & ~evt_wide)) == '0));

    // R4: an event beats a simultaneous clear
    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_wide) |=> ((stat_q & $past(evt_wide)) == $past(evt_wide)));

endmodule

// File: rtl/isr_summary_fsm.sv
module isr_summary_fsm #(
    parameter int          REG_W      = isr_pkg::ISR_REG_W,
    parameter logic [31:0] NORM_GROUP = isr_pkg::ISR_NORM_GROUP,
    parameter logic [31:0] ABN_GROUP  = isr_pkg::ISR_ABN_GROUP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] stat_d,
    output logic             norm_sum,
    output logic             abn_sum,
    output logic             irq
);
    import isr_pkg::*;

    sum_state_e state_q, state_d;
    logic       norm_hit, abn_hit;

    assign norm_hit = |(stat_d & NORM_GROUP[REG_W-1:0]);
    assign abn_hit  = |(stat_d & ABN_GROUP[REG_W-1:0]);

    // next-state choice
    always_comb begin
        unique case ({abn_hit, norm_hit})
            2'b00:   state_d = SUM_IDLE;
            2'b01:   state_d = SUM_NORMAL;
            2'b10:   state_d = SUM_ABNORMAL;
            default: state_d = SUM_BOTH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SUM_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            SUM_IDLE: begin
                norm_sum = 1'b0; abn_sum = 1'b0; irq = 1'b0;
            end
            SUM_NORMAL: begin
                norm_sum = 1'b1; abn_sum = 1'b0; irq = 1'b1;
            end
            SUM_ABNORMAL: begin
                norm_sum = 1'b0; abn_sum = 1'b1; irq = 1'b1;
            end
            default: begin
                norm_sum = 1'b1; abn_sum = 1'b1; irq = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/isr_read_mux.sv
module isr_read_mux #(
    parameter int REG_W   = isr_pkg::ISR_REG_W,
    parameter int FIELD_W = isr_pkg::ISR_FIELD_W
) (
    input  logic [REG_W-1:0] stat_q,
    input  logic             norm_sum,
    input  logic             abn_sum,
    input  logic [REG_W-1:0] mode_in,
    output logic [REG_W-1:0] rd_data
);
    import isr_pkg::*;

    localparam int NUM_FIELDS = 2;
    localparam int FIELD_LSB [NUM_FIELDS] = '{ISR_RX_FIELD_LSB, ISR_TX_FIELD_LSB};
    localparam int START_POS [NUM_FIELDS] = '{ISR_MODE_RX_POS, ISR_MODE_TX_POS};

    logic [REG_W-1:0] field_word [NUM_FIELDS];
    logic             unused_mode;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        assign field_word[f] = mode_in[START_POS[f]]
                             ? (REG_W'({FIELD_W{1'b1}}) << FIELD_LSB[f]) : '0;
    end

    assign unused_mode = ^(mode_in & ~((REG_W'(1) << ISR_MODE_RX_POS) |
                                       (REG_W'(1) << ISR_MODE_TX_POS)));

    always_comb begin
        rd_data                   = stat_q | field_word[0] | field_word[1];
        rd_data[ISR_NORM_SUM_POS] = norm_sum;
        rd_data[ISR_ABN_SUM_POS]  = abn_sum;
    end

endmodule

// File: rtl/isr_status_block.sv
module isr_status_block #(
    parameter int REG_W = isr_pkg::ISR_REG_W,
    parameter int EVT_W = isr_pkg::ISR_EVT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_in,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] mode_in,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_out
);
    import isr_pkg::*;

    logic [REG_W-1:0] stat_q, stat_d;
    logic             norm_sum, abn_sum;

    isr_status_bits #(.REG_W(REG_W), .EVT_W(EVT_W)) i_bits (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .clr_en(wr_en), .clr_data(wr_data),
        .stat_q(stat_q), .stat_d(stat_d)
    );

    isr_summary_fsm #(.REG_W(REG_W)) i_sum (
        .clk(clk), .rst_n(rst_n), .stat_d(stat_d),
        .norm_sum(norm_sum), .abn_sum(abn_sum), .irq(irq_out)
    );

    isr_read_mux #(.REG_W(REG_W)) i_rd (
        .stat_q(stat_q), .norm_sum(norm_sum), .abn_sum(abn_sum),
        .mode_in(mode_in), .rd_data(rd_data)
    );

    // R5: routine summary tracks its group in the read word
    a_r5_norm_summary: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[ISR_NORM_SUM_POS] == |(rd_data & ISR_NORM_GROUP[REG_W-1:0]));

    // R6: error summary tracks its group in the read word
    a_r6_abn_summary: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[ISR_ABN_SUM_POS] == |(rd_data & ISR_ABN_GROUP[REG_W-1:0]));

    // R7: interrupt level follows the summaries
    a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (rd_data[ISR_ABN_SUM_POS] | rd_data[ISR_NORM_SUM_POS]));

endmodule

// File: tb/test_isr_status_block.sv
`timescale 1ns/1ps
module test_isr_status_block;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] evt_in = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] mode_in = '0;
    logic [31:0] rd_data;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    logic [31:0] model;

    always #4 clk = ~clk;

    isr_status_block i_isr_status_block (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en),
        .wr_data(wr_data), .mode_in(mode_in), .rd_data(rd_data), .irq_out(irq_out)
    );

    function automatic logic [31:0] expect_word(input logic [31:0] m, input logic [31:0] md);
        logic [31:0] w;
        w = m;
        if ((m & 32'h0000_0045) != 0) w = w | 32'h0001_0000;
        if ((m & 32'h0000_2BAA) != 0) w = w | 32'h0000_8000;
        if (md[1])  w = w | 32'h0006_0000;
        if (md[13]) w = w | 32'h0030_0000;
        return w;
    endfunction

    // behavioural model: clear first, event second
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model <= 32'hFC00_0000;
        else model <= (model & ~(wr_en ? wr_data : 32'h0))
                    | ({18'h0, evt_in} & 32'h0000_2BEF);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] e;
            e = expect_word(model, mode_in);
            chk(cur_req, rd_data, e);
            chk("R7", {31'h0, irq_out}, {31'h0, (e[15] | e[16])});
        end
    end

    task automatic cyc(input logic [13:0] ev, input logic we, input logic [31:0] wd);
        @(negedge clk); #1;
        evt_in = ev; wr_en = we; wr_data = wd;
        @(negedge clk); #1;
        evt_in = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset value, no interrupt
        chk("R1", rd_data, 32'hFC00_0000);
        chk("R1", {31'h0, irq_out}, 32'h0);

        // R10: upper bits clear by ones
        cur_req = "R10";
        cyc(14'h0, 1'b1, 32'h0400_0000);
        chk("R10", rd_data, 32'hF800_0000);

        // R2 / R5: routine event sets bit and summary
        cur_req = "R2";
        cyc(14'h0001, 1'b0, 32'h0);
        chk("R2", rd_data, 32'hF801_0001);
        chk("R5", {31'h0, irq_out}, 32'h1);

        // R3: zero write keeps, one write clears
        cur_req = "R3";
        cyc(14'h0, 1'b1, 32'h0);
        chk("R3", rd_data, 32'hF801_0001);
        cyc(14'h0, 1'b1, 32'h1);
        chk("R3", rd_data, 32'hF800_0000);
        chk("R3", {31'h0, irq_out}, 32'h0);

        // R6: error event raises abnormal summary
        cur_req = "R6";
        cyc(14'h0800, 1'b0, 32'h0);
        chk("R6", rd_data, 32'hF800_8800);
        cyc(14'h0, 1'b1, 32'h800);
        chk("R6", rd_data, 32'hF800_0000);

        // R9: unused event lines and derived bits ignore stimulus
        cur_req = "R9";
        cyc(14'h1410, 1'b0, 32'h0);
        chk("R9", rd_data, 32'hF800_0000);
        chk("R9", {31'h0, irq_out}, 32'h0);
        cyc(14'h0040, 1'b0, 32'h0);
        cyc(14'h0, 1'b1, 32'h0037_8000);
        chk("R9", rd_data, 32'hF801_0040);

        // R4: event and clear on the same bit
        cur_req = "R4";
        cyc(14'h0040, 1'b1, 32'h40);
        chk("R4", rd_data, 32'hF801_0040);
        cyc(14'h0001, 1'b1, 32'h40);
        chk("R4", rd_data, 32'hF801_0001);

        // R8: process-state fields from mode start bits
        cur_req = "R8";
        @(negedge clk); #1 mode_in = 32'h0000_0002; #1;
        chk("R8", rd_data, 32'hF807_0001);
        mode_in = 32'h0000_2000; #1;
        chk("R8", rd_data, 32'hF831_0001);
        mode_in = 32'h0000_2002; #1;
        chk("R8", rd_data, 32'hF837_0001);
        mode_in = 32'hFFFF_DFFD; #1;
        chk("R8", rd_data, 32'hF801_0001);
        mode_in = 32'h0;

        // R3 / R10: clear everything
        cur_req = "R10";
        cyc(14'h0, 1'b1, 32'hFFFF_FFFF);
        chk("R10", rd_data, 32'h0);
        chk("R7", {31'h0, irq_out}, 32'h0);

        // random collisions of events and clears
        cur_req = "R4";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); #1;
            evt_in  = ($urandom_range(0, 3) == 0) ? 14'($urandom) : 14'h0;
            wr_en   = ($urandom_range(0, 2) == 0);
            wr_data = $urandom;
            if ($urandom_range(0, 15) == 0) mode_in = $urandom;
        end
        @(negedge clk); #1;
        evt_in = '0; wr_en = 1'b0;
        repeat (2) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule